// File: doc/BRIEF.md
# Hit Time Encoder with Phase-Resolved Coarse Count

This block turns one sampled hit into a timestamp. At the moment a hit arrives, two copies of a free-running coarse counter are captured half a clock period apart, along with a 32-bit snapshot of delay-line taps. The block finds the rising clock edge inside the tap snapshot. That edge position becomes the 5-bit fine part of the timestamp. It also tells the block which of the two coarse captures can be trusted: the one taken well away from the counter's own switching instant.

Each channel has an enable, an additive time offset and a dead time counted in clock cycles. A global mode selects what is reported: leading edges only, trailing edges only, both edges as separate results, or a leading edge together with the pulse width measured up to the following trailing edge. A resolution setting drops low bits, so that the result is expressed in bins of 1, 2 or 8 fine steps. This matches the coarser bin sizes of slower interpolation clocks.

Top module: `tdc_time_encoder`

## Requirements
- R1: A rising edge sits at tap k when hit_taps[k]=1 and hit_taps[(k-1) mod 32]=0. If exactly one such k exists, the fine code is k and out_err is 0.
- R2: If the tap snapshot has no rising edge or more than one, out_err is 1. The fine code is then the lowest edge index, or 0 when there is none, and the measurement is still reported.
- R3: A fine code of 0..15 takes the coarse value from cnt_half0. A fine code of 16..31 takes it from cnt_half1.
- R4: out_time is computed as follows. First add the channel's cfg_offset field (bits [c*TW +: TW], TW = coarse width + 5) to {coarse, fine}, modulo 2^TW. Then shift the sum right by 0, 1 or 3 when cfg_res is 0, 1 or 2/3. The result appears with out_valid in the cycle after the hit.
- R5: cfg_mode is decoded as 0 = leading only, 1 = trailing only, 3 = both edges. Edges that the mode does not use produce nothing. A reported edge carries out_trail equal to hit_trail, and out_width is 0.
- R6: In cfg_mode 2 (pair), a leading edge produces no output. It stores its time, replacing any earlier stored time. A trailing edge that follows a stored time reports:
  - out_time is the stored leading time;
  - out_trail is 0;
  - out_width is ((trail − lead) mod 2^TW) shifted as in R4, saturated at 2^WW−1;
  - out_err is the OR of the two edges' errors.
  The trailing edge then clears the stored time. A trailing edge with nothing stored is discarded.
- R7: After an accepted edge on a channel, edges on that channel in the next cfg_dead cycles are discarded and do not restart the dead time.
- R8: Hits on a channel whose cfg_enable bit is 0 produce no output and store nothing.
- R9: Reset clears out_valid, all stored leading times and all dead-time counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Edge mode: 0 lead, 1 trail, 2 pair, 3 both |
| cfg_res | input | 2 | Bin size select: 0, 1 or 2/3 bits dropped as 0/1/3 |
| cfg_dead | input | DW | Dead time in clock cycles |
| cfg_enable | input | NCH | Per-channel enable |
| cfg_offset | input | NCH*TW | Per-channel time offset, TW bits each |
| hit_valid | input | 1 | A hit sample is presented this cycle |
| hit_chan | input | CHW | Channel of the hit |
| hit_trail | input | 1 | 1 for trailing edge, 0 for leading |
| hit_taps | input | 32 | Sampled delay-line taps |
| cnt_half0 | input | CW | Coarse counter captured for fine codes 0..15 |
| cnt_half1 | input | CW | Coarse counter captured for fine codes 16..31 |
| out_valid | output | 1 | Result valid |
| out_chan | output | CHW | Channel of the result |
| out_trail | output | 1 | Edge type of the result |
| out_time | output | TW | Scaled timestamp |
| out_width | output | WW | Scaled, saturated pulse width (pair mode) |
| out_err | output | 1 | Tap snapshot encoding error |

## Verification
Every reported result is registered once, so it appears exactly one clock after the cycle in which its hit was presented. The bench drives each hit on a falling edge and holds it for one cycle. It then reads the outputs at the next falling edge, which is half a period after the capturing rising edge. Discarded hits are confirmed the same way, by seeing out_valid low one cycle after they were presented. Dead-time checks count cycles from the accepted hit and place a blocked hit in the last dead cycle and an accepted one in the first free cycle.

// File: rtl/tdc_enc_pkg.sv
package tdc_enc_pkg;
    localparam int TAPS   = 32;
    localparam int FINE_W = 5;

    typedef enum logic [1:0] {
        MODE_LEAD  = 2'd0,
        MODE_TRAIL = 2'd1,
        MODE_PAIR  = 2'd2,
        MODE_BOTH  = 2'd3
    } tdc_mode_e;

    // bin scaling: number of low bits dropped for each resolution setting
    function automatic logic [1:0] res_shift(input logic [1:0] res);
        case (res)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd3;
        endcase
    endfunction
endpackage

// File: rtl/tdc_fine_encoder.sv
module tdc_fine_encoder #(
    parameter int TAPS = 32,
    localparam int FW  = $clog2(TAPS)
) (
    input  logic [TAPS-1:0] taps,
    output logic [FW-1:0]   fine,
    output logic            err
);
    logic [TAPS-1:0] prev;
    logic [TAPS-1:0] rise;

    always_comb begin
        // prev[k] is the tap just before k, wrapping around the period
        prev = {taps[TAPS-2:0], taps[TAPS-1]};
        rise = taps & ~prev;
        fine = '0;
        for (int k = TAPS - 1; k >= 0; k--) begin
            if (rise[k]) fine = FW'(k);
        end
        err = ($countones(rise) != 1);
    end

    always_comb begin
        if (!err) begin
            a_r1_clean_edge: assert (taps[fine] && !prev[fine]);
        end
        if (taps == '0 || taps == '1) begin
            a_r2_flat_is_error: assert (err);
        end
    end
endmodule

// File: rtl/tdc_dead_timer.sv
module tdc_dead_timer #(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] dead,
    output logic          free
);
    logic [DW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)             cnt_d = dead;
        else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign free = (cnt_q == '0);

    a_r7_dead_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (load && dead != '0) |=> !free);
endmodule

// File: rtl/tdc_time_encoder.sv
module tdc_time_encoder
    import tdc_enc_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 12,
    parameter int WW  = 8,
    parameter int DW  = 4,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int TW  = CW + FINE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic [1:0]        cfg_res,
    input  logic [DW-1:0]     cfg_dead,
    input  logic [NCH-1:0]    cfg_enable,
    input  logic [NCH*TW-1:0] cfg_offset,
    input  logic              hit_valid,
    input  logic [CHW-1:0]    hit_chan,
    input  logic              hit_trail,
    input  logic [TAPS-1:0]   hit_taps,
    input  logic [CW-1:0]     cnt_half0,
    input  logic [CW-1:0]     cnt_half1,
    output logic              out_valid,
    output logic [CHW-1:0]    out_chan,
    output logic              out_trail,
    output logic [TW-1:0]     out_time,
    output logic [WW-1:0]     out_width,
    output logic              out_err
);
    localparam logic [TW-1:0] WSAT = TW'((1 << WW) - 1);

    typedef struct packed {
        logic                   vld;
        logic [CHW-1:0]         chan;
        logic                   trail;
        logic [TW-1:0]          tval;
        logic [WW-1:0]          width;
        logic                   err;
        logic [NCH-1:0]         pend;
        logic [NCH-1:0][TW-1:0] lead_t;
        logic [NCH-1:0]         lead_err;
    } enc_state_t;

    enc_state_t st_d, st_q;

    logic [FINE_W-1:0] fine;
    logic              enc_err;
    logic [NCH-1:0]    free;
    logic [NCH-1:0]    arm;
    logic              relevant;
    logic              accept;
    logic [CW-1:0]     coarse;
    logic [TW-1:0]     stamp;
    logic [TW-1:0]     diff;
    logic [TW-1:0]     dscaled;
    logic [1:0]        sh;
    tdc_mode_e         mode;

    tdc_fine_encoder #(.TAPS(TAPS)) u_fine (
        .taps (hit_taps),
        .fine (fine),
        .err  (enc_err)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_dead
        tdc_dead_timer #(.DW(DW)) u_dead (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (arm[c]),
            .dead  (cfg_dead),
            .free  (free[c])
        );
    end

    always_comb begin
        mode   = tdc_mode_e'(cfg_mode);
        sh     = res_shift(cfg_res);
        // the fine half picks the counter copy sampled away from its toggle
        coarse = fine[FINE_W-1] ? cnt_half1 : cnt_half0;
        stamp  = {coarse, fine} + cfg_offset[int'(hit_chan) * TW +: TW];

        case (mode)
            MODE_LEAD:  relevant = !hit_trail;
            MODE_TRAIL: relevant = hit_trail;
            default:    relevant = 1'b1;
        endcase
        accept = hit_valid && cfg_enable[hit_chan] && free[hit_chan] && relevant;
        for (int c = 0; c < NCH; c++) begin
            arm[c] = accept && (int'(hit_chan) == c);
        end

        diff    = stamp - st_q.lead_t[hit_chan];
        dscaled = diff >> sh;

        st_d     = st_q;
        st_d.vld = 1'b0;
        if (accept) begin
            if (mode == MODE_PAIR) begin
                if (!hit_trail) begin
                    st_d.pend[hit_chan]     = 1'b1;
                    st_d.lead_t[hit_chan]   = stamp;
                    st_d.lead_err[hit_chan] = enc_err;
                end else if (st_q.pend[hit_chan]) begin
                    st_d.pend[hit_chan] = 1'b0;
                    st_d.vld   = 1'b1;
                    st_d.chan  = hit_chan;
                    st_d.trail = 1'b0;
                    st_d.tval  = st_q.lead_t[hit_chan] >> sh;
                    st_d.width = (dscaled > WSAT) ? WSAT[WW-1:0] : dscaled[WW-1:0];
                    st_d.err   = enc_err | st_q.lead_err[hit_chan];
                end
            end else begin
                st_d.vld   = 1'b1;
                st_d.chan  = hit_chan;
                st_d.trail = hit_trail;
                st_d.tval  = stamp >> sh;
                st_d.width = '0;
                st_d.err   = enc_err;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_chan  = st_q.chan;
    assign out_trail = st_q.trail;
    assign out_time  = st_q.tval;
    assign out_width = st_q.width;
    assign out_err   = st_q.err;

    a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && !cfg_enable[hit_chan]) |=> !out_valid);

    a_r5_lead_mode_drops_trail: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && cfg_mode == MODE_LEAD && hit_trail) |=> !out_valid);

    a_r6_pair_lead_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && cfg_mode == MODE_PAIR && !hit_trail) |=> !out_valid);

    a_r4_result_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(hit_valid));
endmodule

// File: tb/tdc_time_encoder_bench.sv
`timescale 1ns/1ps
module tdc_time_encoder_bench;
    localparam int NCH = 4;
    localparam int CW  = 12;
    localparam int WW  = 8;
    localparam int DW  = 4;
    localparam int TW  = CW + 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        cfg_mode = 2'd0;
    logic [1:0]        cfg_res = 2'd0;
    logic [DW-1:0]     cfg_dead = '0;
    logic [NCH-1:0]    cfg_enable = '1;
    logic [NCH*TW-1:0] cfg_offset = '0;
    logic              hit_valid = 1'b0;
    logic [1:0]        hit_chan = '0;
    logic              hit_trail = 1'b0;
    logic [31:0]       hit_taps = '0;
    logic [CW-1:0]     cnt_half0 = '0;
    logic [CW-1:0]     cnt_half1 = '0;
    logic              out_valid;
    logic [1:0]        out_chan;
    logic              out_trail;
    logic [TW-1:0]     out_time;
    logic [WW-1:0]     out_width;
    logic              out_err;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    tdc_time_encoder #(.NCH(NCH), .CW(CW), .WW(WW), .DW(DW)) u_tdc_time_encoder (
        .clk, .rst_n, .cfg_mode, .cfg_res, .cfg_dead, .cfg_enable, .cfg_offset,
        .hit_valid, .hit_chan, .hit_trail, .hit_taps, .cnt_half0, .cnt_half1,
        .out_valid, .out_chan, .out_trail, .out_time, .out_width, .out_err
    );

    // {taps, half0, half1, expected time, expected error}; leading mode, channel 0
    localparam int NVEC = 9;
    localparam logic [73:0] VEC [NVEC] = '{
        {32'h0000FFFF, 12'h122, 12'h123, 17'h02440, 1'b0},
        {32'hFFFF0000, 12'h122, 12'h123, 17'h02470, 1'b0},
        {32'h000001F0, 12'h050, 12'h051, 17'h00A04, 1'b0},
        {32'hC0000000, 12'h7FE, 12'h7FF, 17'h0FFFE, 1'b0},
        {32'h00000000, 12'h010, 12'h011, 17'h00200, 1'b1},
        {32'hFFFFFFFF, 12'h011, 12'h012, 17'h00220, 1'b1},
        {32'h00FF00F0, 12'h020, 12'h021, 17'h00404, 1'b1},
        {32'h80000001, 12'h0AA, 12'h0AB, 17'h0157F, 1'b0},
        {32'h7FFF8000, 12'h001, 12'h002, 17'h0002F, 1'b0}
    };

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    // presents a hit on a falling edge; returns at the next falling edge
    task automatic hit(input int ch, input logic tr, input logic [31:0] tp,
                       input logic [CW-1:0] h0, input logic [CW-1:0] h1);
        hit_valid = 1'b1;
        hit_chan  = 2'(ch);
        hit_trail = tr;
        hit_taps  = tp;
        cnt_half0 = h0;
        cnt_half1 = h1;
        @(negedge clk);
        hit_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input string req, input logic ev, input logic [TW-1:0] et,
                              input logic [WW-1:0] ew, input logic etr, input logic ee);
        logic ok;
        n_checks++;
        if (!ev) ok = (out_valid === 1'b0);
        else     ok = (out_valid === 1'b1) && (out_time === et) && (out_width === ew)
                      && (out_trail === etr) && (out_err === ee);
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got v=%0b t=%h w=%0d tr=%0b e=%0b, expected v=%0b t=%h w=%0d tr=%0b e=%0b",
                     req, out_valid, out_time, out_width, out_trail, out_err, ev, et, ew, etr, ee);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        summary();
        $finish;
    end

    initial begin
        idle(3);
        expect_out("R9 reset output", 1'b0, '0, '0, 1'b0, 1'b0);
        rst_n = 1'b1;
        idle(1);
        expect_out("R9 idle after reset", 1'b0, '0, '0, 1'b0, 1'b0);

        // R1 R2 R3 R4 vector table
        for (int i = 0; i < NVEC; i++) begin
            hit(0, 1'b0, VEC[i][73:42], VEC[i][41:30], VEC[i][29:18]);
            expect_out($sformatf("R1/R2/R3 vector %0d", i), 1'b1, VEC[i][17:1], '0, 1'b0, VEC[i][0]);
            idle(1);
            expect_out($sformatf("R4 single-cycle result %0d", i), 1'b0, '0, '0, 1'b0, 1'b0);
        end

        // R4 offset, wrap and resolution
        cfg_offset[1*TW +: TW] = 17'h00010;
        hit(1, 1'b0, 32'h0000FFFF, 12'h100, 12'h101);
        expect_out("R4 offset add", 1'b1, 17'h02010, '0, 1'b0, 1'b0);
        cfg_offset[1*TW +: TW] = 17'h1FFFF;
        hit(1, 1'b0, 32'h0000FFFF, 12'h000, 12'h001);
        expect_out("R4 offset wrap", 1'b1, 17'h1FFFF, '0, 1'b0, 1'b0);
        cfg_res = 2'd1;
        hit(0, 1'b0, 32'hFFFF0000, 12'h122, 12'h123);
        expect_out("R4 res 1", 1'b1, 17'h01238, '0, 1'b0, 1'b0);
        cfg_res = 2'd2;
        hit(0, 1'b0, 32'hFFFF0000, 12'h122, 12'h123);
        expect_out("R4 res 2", 1'b1, 17'h0048E, '0, 1'b0, 1'b0);
        cfg_res = 2'd0;

        // R5 modes
        hit(0, 1'b1, 32'h0000FFFF, 12'h122, 12'h123);
        expect_out("R5 lead mode drops trail", 1'b0, '0, '0, 1'b0, 1'b0);
        cfg_mode = 2'd1;
        hit(0, 1'b0, 32'h0000FFFF, 12'h122, 12'h123);
        expect_out("R5 trail mode drops lead", 1'b0, '0, '0, 1'b0, 1'b0);
        hit(0, 1'b1, 32'h0000FFFF, 12'h122, 12'h123);
        expect_out("R5 trail mode reports", 1'b1, 17'h02440, '0, 1'b1, 1'b0);
        cfg_mode = 2'd3;
        hit(0, 1'b0, 32'hFFFF0000, 12'h122, 12'h123);
        expect_out("R5 both mode lead", 1'b1, 17'h02470, '0, 1'b0, 1'b0);
        hit(0, 1'b1, 32'h0000FFFF, 12'h122, 12'h123);
        expect_out("R5 both mode trail", 1'b1, 17'h02440, '0, 1'b1, 1'b0);

        // R6 pair mode on channel 2
        cfg_mode = 2'd2;
        hit(2, 1'b0, 32'h0000FFFF, 12'h122, 12'h123);
        expect_out("R6 lead silent", 1'b0, '0, '0, 1'b0, 1'b0);
        hit(2, 1'b1, 32'hFFFF0000, 12'h122, 12'h123);
        expect_out("R6 pair width", 1'b1, 17'h02440, 8'd48, 1'b0, 1'b0);
        hit(2, 1'b1, 32'hFFFF0000, 12'h122, 12'h123);
        expect_out("R6 trail without lead", 1'b0, '0, '0, 1'b0, 1'b0);
        hit(2, 1'b0, 32'h0000FFFF, 12'h122, 12'h123);
        hit(2, 1'b1, 32'hFFFF0000, 12'h132, 12'h133);
        expect_out("R6 width saturates", 1'b1, 17'h02440, 8'd255, 1'b0, 1'b0);
        hit(2, 1'b0, 32'hFFFF0000, 12'hFFE, 12'hFFF);
        hit(2, 1'b1, 32'h0000FFFF, 12'h000, 12'h001);
        expect_out("R6 width wraps", 1'b1, 17'h1FFF0, 8'd16, 1'b0, 1'b0);
        hit(2, 1'b0, 32'h00000000, 12'h100, 12'h101);
        hit(2, 1'b1, 32'h0000FFFF, 12'h101, 12'h102);
        expect_out("R6 error ORed", 1'b1, 17'h02000, 8'd32, 1'b0, 1'b1);

        // R9 reset clears a stored leading time
        hit(2, 1'b0, 32'h0000FFFF, 12'h122, 12'h123);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        hit(2, 1'b1, 32'hFFFF0000, 12'h122, 12'h123);
        expect_out("R9 reset clears pending", 1'b0, '0, '0, 1'b0, 1'b0);

        // R7 dead time of 3 cycles, leading mode
        cfg_mode = 2'd0;
        cfg_dead = 4'd3;
        hit(0, 1'b0, 32'h0000FFFF, 12'h122, 12'h123);
        expect_out("R7 first hit", 1'b1, 17'h02440, '0, 1'b0, 1'b0);
        idle(2);
        hit(0, 1'b0, 32'h0000FFFF, 12'h124, 12'h125);
        expect_out("R7 last dead cycle", 1'b0, '0, '0, 1'b0, 1'b0);
        hit(0, 1'b0, 32'h0000FFFF, 12'h126, 12'h127);
        expect_out("R7 first free cycle", 1'b1, 17'h024C0, '0, 1'b0, 1'b0);
        hit(1, 1'b0, 32'h0000FFFF, 12'h000, 12'h001);
        expect_out("R7 other channel unaffected", 1'b1, 17'h1FFFF, '0, 1'b0, 1'b0);
        cfg_dead = '0;
        idle(4);

        // R8 disabled channel
        cfg_enable = 4'b0111;
        hit(3, 1'b0, 32'h0000FFFF, 12'h122, 12'h123);
        expect_out("R8 disabled channel", 1'b0, '0, '0, 1'b0, 1'b0);
        cfg_mode = 2'd2;
        hit(3, 1'b0, 32'h0000FFFF, 12'h122, 12'h123);
        cfg_enable = 4'b1111;
        hit(3, 1'b1, 32'hFFFF0000, 12'h122, 12'h123);
        expect_out("R8 disabled stores nothing", 1'b0, '0, '0, 1'b0, 1'b0);

        idle(2);
        summary();
        $finish;
    end
endmodule